// File: doc/BRIEF.md
# Serial Flash Program and Erase Engine

This block carries out the write-side commands of an emulated serial flash against a byte-addressed storage array. A command decoder upstream hands it one command at a time: an 8-bit opcode, a 24-bit address, the number of bytes written on the bus (the opcode included), the number of bytes to be read back, and a packed vector of the data bytes that follow the address. The engine checks the command's sizes, works out the byte range it would touch, tests that range against a protected window given by the status logic, and then either refuses the command or runs it.

Program commands write one byte per cycle. Erase commands sweep the array one word per cycle, writing all ones, with the start address aligned down to the erase unit. A word-pair auto-increment mode lets a host stream two bytes per command through an internal pointer; while that mode is active, only a small set of opcodes is accepted. Each accepted command ends in exactly one single-cycle pulse, either `done_o` or `err_o`. A refused command leaves the array untouched. A combinational read port makes the array contents visible.

Top module: `flash_pe_engine`

## Requirements
- R1: The array address is the low log2(ARRAY_BYTES) bits of the 24-bit address, for program and for the read port. A program that runs past the top of the array continues at address 0.
- R2: Opcode 0x02 (program) is refused unless the write count is at least 5 (opcode, three address bytes, one data byte) and the number of data bytes (write count minus 4) is no more than MAX_PROG.
- R3: An accepted program writes data byte k (data_i[8k+7:8k]) to address start+k. It takes one cycle per byte, and done_o rises N+1 cycles after the accepting edge for N bytes.
- R4: Opcode 0xAD outside word-pair mode is refused unless the write count is exactly 6. When accepted, it writes data bytes 0 and 1 at the address, sets aai_o, and leaves the internal pointer at address+2.
- R5: Opcode 0xAD inside word-pair mode is refused unless the write count is exactly 3. When accepted, it writes data bytes 0 and 1 at the pointer, and the pointer then advances by 2.
- R6: While aai_o is high, every opcode other than 0xAD, 0x04 (write disable) and 0x05 (read status) is refused. Opcode 0x04 clears aai_o, and 0x05 completes with no effect.
- R7: Opcodes 0x20, 0x52 and 0xD8 erase ERASE_S_BYTES, ERASE_M_BYTES and ERASE_L_BYTES at the array address aligned down to the unit size. Opcodes 0x60 and 0xC7 erase the whole array. Erased bytes read 0xFF, and bytes outside the unit keep their value.
- R8: An erase with an address needs a write count of 4, and a whole-array erase needs a write count of 1. Both need a read count of 0, or they are refused. An erase opcode whose unit size is configured as 0 completes with done_o and changes nothing.
- R9: A program or erase whose range [start, start+len-1] intersects [wp_start_i, wp_end_i) is refused. A range that ends at wp_start_i-1 or begins at wp_end_i is allowed.
- R10: A refused command pulses err_o for one cycle, in the cycle after it is accepted. It never sets busy_o and leaves the array unchanged. done_o and err_o are never high together.
- R11: An erase takes one cycle per word of WORD_BYTES bytes. While busy_o is high, cmd_ready_o is low and no command is taken. A command held on cmd_valid_i during the sweep is taken on the edge after done_o rises.
- R12: After reset, cmd_ready_o is 1 and busy_o, aai_o, done_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is offered |
| cmd_ready_o | output | 1 | The engine can take a command this cycle |
| opcode_i | input | 8 | Command opcode |
| addr_i | input | 24 | Address, most significant byte first on the bus |
| wr_cnt_i | input | CNT_W | Bytes written on the bus, the opcode included |
| rd_cnt_i | input | CNT_W | Bytes the host reads back |
| data_i | input | MAX_PROG*8 | Data bytes after the address (after the opcode for a word-pair continuation), byte 0 in the low bits |
| wp_start_i | input | 24 | First protected byte address |
| wp_end_i | input | 24 | First byte address past the protected window |
| rd_addr_i | input | 24 | Read port address |
| rd_data_o | output | 8 | Array byte at rd_addr_i |
| busy_o | output | 1 | A program or erase is running |
| aai_o | output | 1 | Word-pair auto-increment mode is active |
| done_o | output | 1 | One-cycle pulse when a command completes |
| err_o | output | 1 | One-cycle pulse when a command is refused |

## Verification
The overlap that matters is a new command arriving while an erase sweep is still running. The bench issues a whole-array erase and, without waiting, raises cmd_valid_i with a one-byte program and holds it through the sweep. The scoreboard queue must then see the erase's done_o before the program's result. The time between the two accepting edges must equal the word count plus one cycle. The programmed byte must hold its new value while its neighbour reads 0xFF, which shows that the program did not land inside the erase.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  localparam logic [7:0] OP_PROG    = 8'h02;
  localparam logic [7:0] OP_WDIS    = 8'h04;
  localparam logic [7:0] OP_RSTAT   = 8'h05;
  localparam logic [7:0] OP_AAI     = 8'hAD;
  localparam logic [7:0] OP_ERASE_S = 8'h20;
  localparam logic [7:0] OP_ERASE_M = 8'h52;
  localparam logic [7:0] OP_ERASE_L = 8'hD8;
  localparam logic [7:0] OP_CHIP_A  = 8'h60;
  localparam logic [7:0] OP_CHIP_B  = 8'hC7;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_FAIL  = 2'd1,
    ACT_PROG  = 2'd2,
    ACT_ERASE = 2'd3
  } act_e;
endpackage

// File: rtl/flash_pe_decode.sv
module flash_pe_decode
  import flash_pe_pkg::*;
#(
  parameter int AW            = 10,
  parameter int CNT_W         = 9,
  parameter int MAX_PROG      = 8,
  parameter int ERASE_S_BYTES = 16,
  parameter int ERASE_M_BYTES = 64,
  parameter int ERASE_L_BYTES = 128,
  parameter bit CE_A_EN       = 1'b1,
  parameter bit CE_B_EN       = 1'b1,
  parameter bit AAI_EN        = 1'b1
) (
  input  logic [7:0]       opcode_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  input  logic [CNT_W-1:0] rd_cnt_i,
  input  logic             aai_active_i,
  input  logic [AW-1:0]    aai_ptr_i,
  output act_e             act_o,
  output logic [AW-1:0]    start_o,
  output logic [AW:0]      len_o,
  output logic             aai_set_o,
  output logic             aai_clr_o
);
  localparam logic [AW-1:0] MASK_S  = ~AW'(ERASE_S_BYTES - 1);
  localparam logic [AW-1:0] MASK_M  = ~AW'(ERASE_M_BYTES - 1);
  localparam logic [AW-1:0] MASK_L  = ~AW'(ERASE_L_BYTES - 1);
  localparam logic [AW:0]   LEN_S   = (AW+1)'(ERASE_S_BYTES);
  localparam logic [AW:0]   LEN_M   = (AW+1)'(ERASE_M_BYTES);
  localparam logic [AW:0]   LEN_L   = (AW+1)'(ERASE_L_BYTES);
  localparam logic [AW:0]   LEN_ALL = (AW+1)'(1) << AW;

  logic addr_ok, chip_ok, gated;

  assign addr_ok = (wr_cnt_i == CNT_W'(4)) && (rd_cnt_i == '0);
  assign chip_ok = (wr_cnt_i == CNT_W'(1)) && (rd_cnt_i == '0);
  assign gated   = aai_active_i && (opcode_i != OP_AAI) &&
                   (opcode_i != OP_WDIS) && (opcode_i != OP_RSTAT);

  always_comb begin
    act_o     = ACT_NONE;
    start_o   = addr_i;
    len_o     = '0;
    aai_set_o = 1'b0;
    aai_clr_o = 1'b0;
    if (gated) begin
      act_o = ACT_FAIL;
    end else begin
      case (opcode_i)
        OP_PROG: begin
          if (wr_cnt_i < CNT_W'(5) || (wr_cnt_i - CNT_W'(4)) > CNT_W'(MAX_PROG)) begin
            act_o = ACT_FAIL;
          end else begin
            act_o = ACT_PROG;
            len_o = (AW+1)'(wr_cnt_i - CNT_W'(4));
          end
        end
        OP_AAI: begin
          if (AAI_EN) begin
            if (!aai_active_i) begin
              if (wr_cnt_i != CNT_W'(6)) act_o = ACT_FAIL;
              else begin
                act_o     = ACT_PROG;
                len_o     = (AW+1)'(2);
                aai_set_o = 1'b1;
              end
            end else begin
              if (wr_cnt_i != CNT_W'(3)) act_o = ACT_FAIL;
              else begin
                act_o   = ACT_PROG;
                start_o = aai_ptr_i;
                len_o   = (AW+1)'(2);
              end
            end
          end
        end
        OP_WDIS: aai_clr_o = AAI_EN;
        OP_ERASE_S: begin
          if (ERASE_S_BYTES != 0) begin
            if (!addr_ok) act_o = ACT_FAIL;
            else begin
              act_o   = ACT_ERASE;
              start_o = addr_i & MASK_S;
              len_o   = LEN_S;
            end
          end
        end
        OP_ERASE_M: begin
          if (ERASE_M_BYTES != 0) begin
            if (!addr_ok) act_o = ACT_FAIL;
            else begin
              act_o   = ACT_ERASE;
              start_o = addr_i & MASK_M;
              len_o   = LEN_M;
            end
          end
        end
        OP_ERASE_L: begin
          if (ERASE_L_BYTES != 0) begin
            if (!addr_ok) act_o = ACT_FAIL;
            else begin
              act_o   = ACT_ERASE;
              start_o = addr_i & MASK_L;
              len_o   = LEN_L;
            end
          end
        end
        OP_CHIP_A, OP_CHIP_B: begin
          if ((opcode_i == OP_CHIP_A) ? CE_A_EN : CE_B_EN) begin
            if (!chip_ok) act_o = ACT_FAIL;
            else begin
              act_o   = ACT_ERASE;
              start_o = '0;
              len_o   = LEN_ALL;
            end
          end
        end
        default: act_o = ACT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/flash_pe_guard.sv
module flash_pe_guard #(
  parameter int AW = 10
) (
  input  logic [AW-1:0] start_i,
  input  logic [AW:0]   len_i,
  input  logic [23:0]   wp_start_i,
  input  logic [23:0]   wp_end_i,
  output logic          hit_o
);
  logic [24:0] first, last;

  assign first = 25'(start_i);
  assign last  = first + 25'(len_i) - 25'd1;
  // Empty ranges never intersect.
  assign hit_o = (len_i != '0) && (first < {1'b0, wp_end_i}) &&
                 (last >= {1'b0, wp_start_i});
endmodule

// File: rtl/flash_pe_array.sv
module flash_pe_array #(
  parameter int AW         = 10,
  parameter int WORD_BYTES = 4
) (
  input  logic                            clk_i,
  input  logic                            bwr_en_i,
  input  logic [AW-1:0]                   bwr_addr_i,
  input  logic [7:0]                      bwr_data_i,
  input  logic                            wclr_en_i,
  input  logic [AW-$clog2(WORD_BYTES)-1:0] wclr_idx_i,
  input  logic [AW-1:0]                   rd_addr_i,
  output logic [7:0]                      rd_data_o
);
  localparam int LANE_W = $clog2(WORD_BYTES);
  localparam int NWORDS = (2 ** AW) / WORD_BYTES;
  localparam int WBITS  = WORD_BYTES * 8;

  logic [WBITS-1:0] mem [NWORDS];

  always_ff @(posedge clk_i) begin
    if (wclr_en_i) begin
      mem[wclr_idx_i] <= '1;
    end else if (bwr_en_i) begin
      mem[bwr_addr_i[AW-1:LANE_W]][{bwr_addr_i[LANE_W-1:0], 3'b000} +: 8] <= bwr_data_i;
    end
  end

  assign rd_data_o = mem[rd_addr_i[AW-1:LANE_W]][{rd_addr_i[LANE_W-1:0], 3'b000} +: 8];
endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine
  import flash_pe_pkg::*;
#(
  parameter int ARRAY_BYTES   = 1024,
  parameter int WORD_BYTES    = 4,
  parameter int MAX_PROG      = 8,
  parameter int CNT_W         = 9,
  parameter int ERASE_S_BYTES = 16,
  parameter int ERASE_M_BYTES = 64,
  parameter int ERASE_L_BYTES = 128,
  parameter bit CE_A_EN       = 1'b1,
  parameter bit CE_B_EN       = 1'b1,
  parameter bit AAI_EN        = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  output logic                  cmd_ready_o,
  input  logic [7:0]            opcode_i,
  input  logic [23:0]           addr_i,
  input  logic [CNT_W-1:0]      wr_cnt_i,
  input  logic [CNT_W-1:0]      rd_cnt_i,
  input  logic [MAX_PROG*8-1:0] data_i,
  input  logic [23:0]           wp_start_i,
  input  logic [23:0]           wp_end_i,
  input  logic [23:0]           rd_addr_i,
  output logic [7:0]            rd_data_o,
  output logic                  busy_o,
  output logic                  aai_o,
  output logic                  done_o,
  output logic                  err_o
);
  localparam int AW     = $clog2(ARRAY_BYTES);
  localparam int LANE_W = $clog2(WORD_BYTES);
  localparam int WIW    = AW - LANE_W;
  localparam int PLW    = MAX_PROG * 8;

  act_e            dec_act;
  logic [AW-1:0]   dec_start;
  logic [AW:0]     dec_len;
  logic            dec_aai_set, dec_aai_clr, prot_hit;

  logic            busy_q, erase_q, aai_q, done_q, err_q;
  logic [AW-1:0]   cur_q, ptr_q;
  logic [WIW-1:0]  widx_q;
  logic [AW:0]     rem_q;
  logic [PLW-1:0]  buf_q;

  logic accept, runs, go_fail, go_none, go_run;
  logic unused_hi;

  assign unused_hi = ^{addr_i[23:AW], rd_addr_i[23:AW]};

  flash_pe_decode #(
    .AW(AW), .CNT_W(CNT_W), .MAX_PROG(MAX_PROG),
    .ERASE_S_BYTES(ERASE_S_BYTES), .ERASE_M_BYTES(ERASE_M_BYTES),
    .ERASE_L_BYTES(ERASE_L_BYTES), .CE_A_EN(CE_A_EN), .CE_B_EN(CE_B_EN),
    .AAI_EN(AAI_EN)
  ) u_decode (
    .opcode_i    (opcode_i),
    .addr_i      (addr_i[AW-1:0]),
    .wr_cnt_i    (wr_cnt_i),
    .rd_cnt_i    (rd_cnt_i),
    .aai_active_i(aai_q),
    .aai_ptr_i   (ptr_q),
    .act_o       (dec_act),
    .start_o     (dec_start),
    .len_o       (dec_len),
    .aai_set_o   (dec_aai_set),
    .aai_clr_o   (dec_aai_clr)
  );

  flash_pe_guard #(.AW(AW)) u_guard (
    .start_i   (dec_start),
    .len_i     (dec_len),
    .wp_start_i(wp_start_i),
    .wp_end_i  (wp_end_i),
    .hit_o     (prot_hit)
  );

  flash_pe_array #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_array (
    .clk_i     (clk_i),
    .bwr_en_i  (busy_q && !erase_q),
    .bwr_addr_i(cur_q),
    .bwr_data_i(buf_q[7:0]),
    .wclr_en_i (busy_q && erase_q),
    .wclr_idx_i(widx_q),
    .rd_addr_i (rd_addr_i[AW-1:0]),
    .rd_data_o (rd_data_o)
  );

  assign accept  = cmd_valid_i && !busy_q;
  assign runs    = (dec_act == ACT_PROG) || (dec_act == ACT_ERASE);
  assign go_fail = accept && ((dec_act == ACT_FAIL) || (runs && prot_hit));
  assign go_none = accept && (dec_act == ACT_NONE);
  assign go_run  = accept && runs && !prot_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      erase_q <= 1'b0;
      aai_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      cur_q   <= '0;
      ptr_q   <= '0;
      widx_q  <= '0;
      rem_q   <= '0;
      buf_q   <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (go_fail) begin
        err_q <= 1'b1;
      end else if (go_none) begin
        done_q <= 1'b1;
        if (dec_aai_clr) aai_q <= 1'b0;
      end else if (go_run) begin
        busy_q  <= 1'b1;
        erase_q <= (dec_act == ACT_ERASE);
        cur_q   <= dec_start;
        widx_q  <= dec_start[AW-1:LANE_W];
        rem_q   <= (dec_act == ACT_ERASE) ? (dec_len >> LANE_W) : dec_len;
        buf_q   <= data_i;
        if (dec_aai_set) aai_q <= 1'b1;
        if (opcode_i == OP_AAI) ptr_q <= dec_start + AW'(2);
      end else if (busy_q) begin
        // one byte (program) or one word (erase) per cycle
        cur_q  <= cur_q + AW'(1);
        widx_q <= widx_q + WIW'(1);
        buf_q  <= buf_q >> 8;
        rem_q  <= rem_q - (AW+1)'(1);
        if (rem_q == (AW+1)'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign cmd_ready_o = !busy_q;
  assign busy_o      = busy_q;
  assign aai_o       = aai_q;
  assign done_o      = done_q;
  assign err_o       = err_q;

  assert_one_result_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  assert_fail_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);
  assert_done_at_end_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_aai_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aai_o) |-> $past(cmd_valid_i && cmd_ready_o && opcode_i == OP_AAI));
  assert_aai_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(aai_o) |-> $past(cmd_valid_i && cmd_ready_o && opcode_i == OP_WDIS));
  assert_aai_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && aai_o && opcode_i != OP_AAI &&
     opcode_i != OP_WDIS && opcode_i != OP_RSTAT) |=> err_o);
  assert_prog_short_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && !aai_o && opcode_i == OP_PROG &&
     wr_cnt_i < CNT_W'(5)) |=> err_o);
  assert_erase_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && !aai_o && opcode_i == OP_ERASE_L &&
     ERASE_L_BYTES != 0 && wr_cnt_i != CNT_W'(4)) |=> err_o);
endmodule

// File: tb/flash_pe_engine_tb.sv
module flash_pe_engine_tb;
  localparam int ARRAY = 1024;
  localparam int WB    = 4;
  localparam int MAXP  = 8;
  localparam int CW    = 9;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic              cmd_valid;
  logic              cmd_ready;
  logic [7:0]        opcode;
  logic [23:0]       addr;
  logic [CW-1:0]     wr_cnt, rd_cnt;
  logic [MAXP*8-1:0] data;
  logic [23:0]       wp_start, wp_end, rd_addr;
  logic [7:0]        rd_data;
  logic              busy, aai, done, err;

  flash_pe_engine #(
    .ARRAY_BYTES(ARRAY), .WORD_BYTES(WB), .MAX_PROG(MAXP), .CNT_W(CW),
    .ERASE_S_BYTES(16), .ERASE_M_BYTES(0), .ERASE_L_BYTES(128)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .opcode_i(opcode), .addr_i(addr), .wr_cnt_i(wr_cnt), .rd_cnt_i(rd_cnt),
    .data_i(data), .wp_start_i(wp_start), .wp_end_i(wp_end),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .busy_o(busy), .aai_o(aai),
    .done_o(done), .err_o(err)
  );

  typedef struct { bit err; string req; } exp_t;
  exp_t expq[$];
  int checks = 0, fails = 0;
  bit ended = 1'b0;
  logic [7:0] model [ARRAY];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (done || err)) begin
      if (expq.size() == 0) begin
        check(1'b0, "R10", "unexpected result pulse", {30'd0, done, err}, 32'd0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(err == e.err && done == !e.err, e.req, "result err flag", err, e.err);
      end
    end
  end

  task automatic send(input logic [7:0] op, input logic [23:0] a, input int wr,
                      input int rd, input logic [63:0] d, input bit exp_err,
                      input string req, input bit wait_res,
                      output time acc_t, output int lat);
    exp_t e;
    time res_t;
    @(negedge clk);
    opcode = op; addr = a; wr_cnt = CW'(wr); rd_cnt = CW'(rd); data = d;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    acc_t = $time;
    e.err = exp_err; e.req = req;
    expq.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 0;
    if (wait_res) begin
      wait (expq.size() == 0);
      res_t = $time;
      lat = int'((res_t - acc_t + 5) / 10);
    end
  endtask

  task automatic prog(input logic [23:0] a, input int n, input logic [63:0] d,
                      input bit exp_err, input string req, output int lat);
    time t;
    send(8'h02, a, n + 4, 0, d, exp_err, req, 1'b1, t, lat);
    if (!exp_err)
      for (int i = 0; i < n; i++) model[(int'(a) + i) % ARRAY] = d[8*i +: 8];
  endtask

  task automatic erase(input logic [7:0] op, input logic [23:0] a, input int wr,
                       input int rd, input int sz, input bit exp_err,
                       input string req, output int lat);
    time t;
    int base;
    send(op, a, wr, rd, 64'd0, exp_err, req, 1'b1, t, lat);
    if (!exp_err && sz != 0) begin
      base = (int'(a) % ARRAY) & ~(sz - 1);
      for (int i = 0; i < sz; i++) model[base + i] = 8'hFF;
    end
  endtask

  task automatic rd_chk(input logic [23:0] a, input string req);
    @(negedge clk);
    rd_addr = a;
    #1;
    check(rd_data === model[int'(a) % ARRAY], req, "read byte", rd_data, model[int'(a) % ARRAY]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R11", "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    int lat;
    time t0, t1;
    rst_n = 1'b0; cmd_valid = 1'b0; opcode = '0; addr = '0; wr_cnt = '0;
    rd_cnt = '0; data = '0; wp_start = '0; wp_end = '0; rd_addr = '0;
    for (int i = 0; i < ARRAY; i++) model[i] = 8'hxx;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12 reset state
    check(cmd_ready && !busy && !aai && !done && !err, "R12", "reset outputs",
          {cmd_ready, busy, aai, done, err}, 5'b10000);

    // R7 R11 whole-array erase, 256 words
    erase(8'hC7, 24'h0, 1, 0, ARRAY, 1'b0, "R7", lat);
    check(lat == ARRAY / WB + 1, "R11", "chip erase latency", lat, ARRAY / WB + 1);
    rd_chk(24'h000, "R7");
    rd_chk(24'h3FF, "R7");

    // R3 program three bytes
    prog(24'h000010, 3, 64'hA3A2A1, 1'b0, "R3", lat);
    check(lat == 4, "R3", "program latency", lat, 4);
    rd_chk(24'h010, "R3"); rd_chk(24'h011, "R3"); rd_chk(24'h012, "R3"); rd_chk(24'h013, "R3");

    // R1 address reduction and wrap
    prog(24'h0403FE, 4, 64'hD4D3D2D1, 1'b0, "R1", lat);
    rd_chk(24'h3FF, "R1"); rd_chk(24'h000, "R1"); rd_chk(24'h001, "R1");
    rd_chk(24'h0007FF, "R1");

    // R2 size limits
    prog(24'h000100, 0, 64'h0, 1'b1, "R2", lat);
    check(lat == 1, "R10", "refused latency", lat, 1);
    begin
      time t;
      send(8'h02, 24'h000100, 13, 0, 64'hFFFF, 1'b1, "R2", 1'b1, t, lat);
    end
    rd_chk(24'h100, "R2");
    prog(24'h000100, 8, 64'h1817161514131211, 1'b0, "R2", lat);
    rd_chk(24'h107, "R2");

    // R9 R10 protection window 0x200..0x23F
    prog(24'h000230, 1, 64'h5A, 1'b0, "R9", lat);
    wp_start = 24'h000200; wp_end = 24'h000240;
    prog(24'h0001FE, 2, 64'hC2C1, 1'b0, "R9", lat);
    rd_chk(24'h1FF, "R9");
    prog(24'h0001FF, 2, 64'hE2E1, 1'b1, "R9", lat);
    rd_chk(24'h1FF, "R10"); rd_chk(24'h200, "R10");
    prog(24'h000240, 1, 64'h77, 1'b0, "R9", lat);
    rd_chk(24'h240, "R9");
    prog(24'h00023F, 1, 64'h88, 1'b1, "R9", lat);
    erase(8'h20, 24'h000235, 4, 0, 16, 1'b1, "R9", lat);
    rd_chk(24'h230, "R10");
    check(!busy, "R10", "no busy after refusal", busy, 0);
    wp_start = '0; wp_end = '0;

    // R7 sector erase aligned down
    prog(24'h000305, 1, 64'h55, 1'b0, "R7", lat);
    prog(24'h00030F, 2, 64'h7766, 1'b0, "R7", lat);
    erase(8'h20, 24'h00030A, 4, 0, 16, 1'b0, "R7", lat);
    check(lat == 16 / WB + 1, "R11", "sector erase latency", lat, 16 / WB + 1);
    rd_chk(24'h305, "R7"); rd_chk(24'h30F, "R7"); rd_chk(24'h310, "R7");

    // R7 large unit: 0x380..0x3FF
    prog(24'h00037F, 1, 64'h3C, 1'b0, "R7", lat);
    erase(8'hD8, 24'h0003C0, 4, 0, 128, 1'b0, "R7", lat);
    rd_chk(24'h3FE, "R7"); rd_chk(24'h380, "R7"); rd_chk(24'h37F, "R7");

    // R8 erase size checks and disabled unit
    erase(8'h20, 24'h000010, 5, 0, 16, 1'b1, "R8", lat);
    erase(8'h20, 24'h000010, 4, 1, 16, 1'b1, "R8", lat);
    erase(8'h60, 24'h000000, 4, 0, ARRAY, 1'b1, "R8", lat);
    rd_chk(24'h010, "R8");
    erase(8'h52, 24'h000000, 4, 0, 0, 1'b0, "R8", lat);
    rd_chk(24'h000, "R8"); rd_chk(24'h011, "R8");

    // R4 R5 R6 word-pair mode
    begin
      time t;
      send(8'hAD, 24'h000050, 5, 0, 64'h2211, 1'b1, "R4", 1'b1, t, lat);
      check(!aai, "R4", "mode after bad entry", aai, 0);
      send(8'hAD, 24'h000050, 6, 0, 64'h2211, 1'b0, "R4", 1'b1, t, lat);
      model[16'h50] = 8'h11; model[16'h51] = 8'h22;
      check(aai, "R4", "mode flag set", aai, 1);
      rd_chk(24'h050, "R4"); rd_chk(24'h051, "R4");
      send(8'hAD, 24'h000000, 3, 0, 64'h4433, 1'b0, "R5", 1'b1, t, lat);
      model[16'h52] = 8'h33; model[16'h53] = 8'h44;
      rd_chk(24'h052, "R5"); rd_chk(24'h053, "R5");
      send(8'hAD, 24'h000000, 6, 0, 64'h6655, 1'b1, "R5", 1'b1, t, lat);
      rd_chk(24'h054, "R5");
      send(8'hAD, 24'h000000, 3, 0, 64'h6655, 1'b0, "R5", 1'b1, t, lat);
      model[16'h54] = 8'h55; model[16'h55] = 8'h66;
      rd_chk(24'h054, "R5"); rd_chk(24'h055, "R5");
      send(8'h02, 24'h000060, 5, 0, 64'h99, 1'b1, "R6", 1'b1, t, lat);
      rd_chk(24'h060, "R6");
      send(8'h20, 24'h000050, 4, 0, 64'h0, 1'b1, "R6", 1'b1, t, lat);
      rd_chk(24'h050, "R6");
      send(8'h05, 24'h000000, 1, 1, 64'h0, 1'b0, "R6", 1'b1, t, lat);
      check(aai, "R6", "mode kept by status read", aai, 1);
      send(8'h04, 24'h000000, 1, 0, 64'h0, 1'b0, "R6", 1'b1, t, lat);
      check(!aai, "R6", "mode cleared by write disable", aai, 0);
      send(8'hAD, 24'h000000, 3, 0, 64'h0, 1'b1, "R4", 1'b1, t, lat);
      check(!aai, "R4", "short entry after exit", aai, 0);
    end

    // R11 command held during an erase sweep
    send(8'h60, 24'h0, 1, 0, 64'h0, 1'b0, "R11", 1'b0, t0, lat);
    for (int i = 0; i < ARRAY; i++) model[i] = 8'hFF;
    send(8'h02, 24'h000010, 5, 0, 64'hBE, 1'b0, "R11", 1'b1, t1, lat);
    model[16'h10] = 8'hBE;
    check((t1 - t0) == 10 * (ARRAY / WB + 1), "R11", "accept spacing cycles",
          32'((t1 - t0) / 10), ARRAY / WB + 1);
    rd_chk(24'h010, "R11"); rd_chk(24'h011, "R11"); rd_chk(24'h052, "R11");

    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R10", "pending results", expq.size(), 0);
    finish_run();
  end
endmodule